// File: doc/BRIEF.md
# Variable-Latency Issue Scoreboard

This block decides, cycle by cycle, whether the next instruction of a single-issue in-order pipeline may leave the issue stage. Three kinds of execution unit share one register-file write port. The first is a single-cycle integer unit. The second is a pipelined multiplier with a fixed latency. The third is an iterative divider that is not pipelined. For the divider, the latency is handed over at issue. The candidate presents its unit type, two source registers and a destination. The block answers combinationally with a stall flag and an issue flag.

Internally it keeps a pending bit per architectural register and a short reservation line that records which future cycle owns the write port. The line also records which register is written in that cycle. When a single-cycle result would land on the same cycle as a multiply already in flight, the multiply is pushed back by one cycle and the new result takes the slot. A divide holds a busy counter. As it nears completion, it claims a free port slot ahead of any candidate that has not yet issued. The port owner of each cycle is presented as registered outputs, together with a one-cycle divide-completion pulse.

Top module: `sbd_issue_ctrl`

## Requirements
- R1: A single-cycle operation issued in cycle N (unit code 0, and code 3 behaves the same) appears on the writeback outputs in cycle N+1, with its destination on wb_reg_o and unit code 0 on wb_unit_o.
- R2: A multiply (unit code 1) issued in cycle N appears on the writeback outputs in cycle N+3 unless it has been pushed back (R6).
- R3: A valid candidate stalls while any nonzero source register is the destination of an issued operation whose writeback cycle has not yet ended; it may issue in the cycle after that writeback.
- R4: A valid candidate stalls while its nonzero destination is the destination of an issued operation whose writeback cycle has not yet ended.
- R5: Register 0 never causes a stall as a source or destination, and writing it sets no pending state.
- R6: At most one result uses the write port per cycle; when a single-cycle operation issues while a multiply would write back in the next cycle, the single-cycle result takes that cycle and the multiply writes back one cycle later.
- R7: A single-cycle candidate stalls when both the next writeback cycle and the one after it are already held by multiplies.
- R8: A divide (unit code 2) stalls while an earlier divide is busy, including the cycle in which that earlier divide writes back; div_busy_o is high from the cycle after issue through the writeback cycle.
- R9: A divide issued in cycle N with latency L writes back in cycle N+L when the port is free, a latency below 2 being treated as 2, and div_done_o is high for exactly that one cycle with unit code 2 on wb_unit_o.
- R10: In the cycle before a divide writes back, and in any cycle where it is waiting to claim the port, a single-cycle candidate stalls.
- R11: A divide whose completion cycle is already held by an in-flight multiply waits, and writes back one cycle after that multiply.
- R12: Synchronous reset clears all pending registers, the reservation line and the divider's busy state.
- R13: issue_o equals in_valid with no stall, and stall_o is low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate instruction present |
| in_unit | input | 2 | Unit code: 0 single-cycle, 1 multiply, 2 divide, 3 as 0 |
| in_src_a | input | $clog2(NREG) | First source register |
| in_src_b | input | $clog2(NREG) | Second source register |
| in_dst | input | $clog2(NREG) | Destination register |
| in_div_lat | input | LATW | Divide latency in cycles, used when in_unit is 2 |
| stall_o | output | 1 | Candidate must wait this cycle |
| issue_o | output | 1 | Candidate leaves issue this cycle |
| wb_valid_o | output | 1 | Write port in use this cycle |
| wb_reg_o | output | $clog2(NREG) | Register written this cycle |
| wb_unit_o | output | 2 | Unit code of the result written this cycle |
| div_done_o | output | 1 | Divide result written this cycle |
| div_busy_o | output | 1 | A divide is in progress |

## Verification
The hardest situation to reach is a divide that finds its completion cycle already held by a multiply, since it needs a divide latency and a later multiply issue lined up to the same writeback cycle. The stimulus issues a four-cycle divide and a multiply one cycle later, then offers a single-cycle candidate across the following cycles to observe both the divide's priority and its one-cycle yield. A second hard case is a multiply pushed back by a single-cycle result: a multiply is issued, one idle cycle passes, then the single-cycle candidate arrives exactly when the multiply sits one slot from writeback; two back-to-back multiplies then fill both slots to force the stall.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;

  typedef enum logic [1:0] {
    UNIT_ALU = 2'd0,
    UNIT_MUL = 2'd1,
    UNIT_DIV = 2'd2,
    UNIT_RSV = 2'd3
  } unit_e;

  localparam int ALU_LAT = 1;

  // Per-unit latency table for the fixed-latency units.
  function automatic int unit_latency(logic [1:0] u, int mul_lat);
    if (u == UNIT_MUL) return mul_lat;
    return ALU_LAT;
  endfunction

  // Slot index in the reservation line, counted in the shifted frame.
  function automatic int wb_slot(int lat);
    return lat - 1;
  endfunction

endpackage

// File: rtl/sbd_pend.sv
`timescale 1ns/1ps
module sbd_pend #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_reg,
  input  logic [RW-1:0] q_a,
  input  logic [RW-1:0] q_b,
  input  logic [RW-1:0] q_d,
  output logic          hit_a,
  output logic          hit_b,
  output logic          hit_d
);

  logic [NREG-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      if (clr_en) pend[clr_reg] <= 1'b0;
      if (set_en && set_reg != '0) pend[set_reg] <= 1'b1;
    end
  end

  assign hit_a = (q_a != '0) && pend[q_a];
  assign hit_b = (q_b != '0) && pend[q_b];
  assign hit_d = (q_d != '0) && pend[q_d];

  // R3
  set_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_reg != '0) |=> pend[$past(set_reg)]);

  // R4
  waw_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_reg != '0) |-> !pend[set_reg]);

endmodule

// File: rtl/sbd_wb_ring.sv
`timescale 1ns/1ps
module sbd_wb_ring
  import sbd_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_put,
  input  logic          mul_put,
  input  logic          div_put,
  input  logic [RW-1:0] put_dst,
  input  logic [RW-1:0] div_dst,
  output logic          sh0_v,
  output logic          sh1_v,
  output logic          wb_v,
  output logic [RW-1:0] wb_dst,
  output logic [1:0]    wb_unit
);

  localparam int ALU_SLOT = wb_slot(unit_latency(UNIT_ALU, DEPTH));
  localparam int MUL_SLOT = wb_slot(unit_latency(UNIT_MUL, DEPTH));

  logic [DEPTH-1:0]         slot_v, sh_v, nxt_v;
  logic [DEPTH-1:0][1:0]    slot_u, sh_u, nxt_u;
  logic [DEPTH-1:0][RW-1:0] slot_d, sh_d, nxt_d;

  // View of the line as it will look after one shift.
  for (genvar k = 0; k < DEPTH; k++) begin : g_shift
    if (k < DEPTH - 1) begin : g_mv
      assign sh_v[k] = slot_v[k+1];
      assign sh_u[k] = slot_u[k+1];
      assign sh_d[k] = slot_d[k+1];
    end else begin : g_end
      assign sh_v[k] = 1'b0;
      assign sh_u[k] = '0;
      assign sh_d[k] = '0;
    end
  end

  always_comb begin
    nxt_v = sh_v;
    nxt_u = sh_u;
    nxt_d = sh_d;
    if (alu_put) begin
      if (sh_v[ALU_SLOT]) begin
        nxt_v[ALU_SLOT+1] = 1'b1;
        nxt_u[ALU_SLOT+1] = sh_u[ALU_SLOT];
        nxt_d[ALU_SLOT+1] = sh_d[ALU_SLOT];
      end
      nxt_v[ALU_SLOT] = 1'b1;
      nxt_u[ALU_SLOT] = UNIT_ALU;
      nxt_d[ALU_SLOT] = put_dst;
    end
    if (div_put) begin
      nxt_v[0] = 1'b1;
      nxt_u[0] = UNIT_DIV;
      nxt_d[0] = div_dst;
    end
    if (mul_put) begin
      nxt_v[MUL_SLOT] = 1'b1;
      nxt_u[MUL_SLOT] = UNIT_MUL;
      nxt_d[MUL_SLOT] = put_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= '0;
      slot_u <= '0;
      slot_d <= '0;
    end else begin
      slot_v <= nxt_v;
      slot_u <= nxt_u;
      slot_d <= nxt_d;
    end
  end

  assign sh0_v   = sh_v[0];
  assign sh1_v   = sh_v[1];
  assign wb_v    = slot_v[0];
  assign wb_dst  = slot_d[0];
  assign wb_unit = slot_u[0];

  // R6
  mul_pushback_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_put && sh_v[0]) |=> (slot_v[1] && slot_u[1] == UNIT_MUL));

  // R7
  bump_room_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_put && sh_v[0]) |-> !sh_v[1]);

  // R10
  port_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !(alu_put && div_put));

endmodule

// File: rtl/sbd_div_track.sv
`timescale 1ns/1ps
module sbd_div_track #(
  parameter int LATW = 6,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [LATW-1:0] lat,
  input  logic [RW-1:0]   dst,
  input  logic            sh0_v,
  input  logic            done,
  output logic            busy,
  output logic            want,
  output logic            claim,
  output logic [RW-1:0]   held_dst
);

  logic [LATW-1:0] cnt;

  assign want  = busy && (cnt == LATW'(1));
  assign claim = want && !sh0_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      held_dst <= '0;
    end else if (issue) begin
      busy     <= 1'b1;
      cnt      <= (lat < LATW'(2)) ? LATW'(1) : lat - LATW'(1);
      held_dst <= dst;
    end else begin
      if (done) busy <= 1'b0;
      if (claim) cnt <= '0;
      else if (busy && cnt > LATW'(1)) cnt <= cnt - LATW'(1);
    end
  end

  // R8
  div_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !busy);

  // R9
  claim_lands_chk: assert property (@(posedge clk) disable iff (rst)
    claim |=> done);

  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/sbd_issue_ctrl.sv
`timescale 1ns/1ps
module sbd_issue_ctrl
  import sbd_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int MUL_LAT = 3,
  parameter int LATW    = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_unit,
  input  logic [$clog2(NREG)-1:0] in_src_a,
  input  logic [$clog2(NREG)-1:0] in_src_b,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [LATW-1:0]         in_div_lat,
  output logic                    stall_o,
  output logic                    issue_o,
  output logic                    wb_valid_o,
  output logic [$clog2(NREG)-1:0] wb_reg_o,
  output logic [1:0]              wb_unit_o,
  output logic                    div_done_o,
  output logic                    div_busy_o
);

  localparam int RW    = $clog2(NREG);
  localparam int DEPTH = MUL_LAT;

  logic is_mul, is_div, is_alu;
  logic hit_a, hit_b, hit_d;
  logic sh0_v, sh1_v;
  logic div_want, div_claim, div_busy;
  logic [RW-1:0] div_dst;
  logic hazard;

  assign is_mul = (in_unit == UNIT_MUL);
  assign is_div = (in_unit == UNIT_DIV);
  assign is_alu = !is_mul && !is_div;

  assign hazard = hit_a || hit_b || hit_d
                || (is_div && div_busy)
                || (is_alu && (div_want || (sh0_v && sh1_v)));

  assign stall_o = in_valid && hazard;
  assign issue_o = in_valid && !hazard;

  assign div_done_o = wb_valid_o && (wb_unit_o == UNIT_DIV);
  assign div_busy_o = div_busy;

  sbd_pend #(.NREG(NREG), .RW(RW)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_en  (issue_o),
    .set_reg (in_dst),
    .clr_en  (wb_valid_o),
    .clr_reg (wb_reg_o),
    .q_a     (in_src_a),
    .q_b     (in_src_b),
    .q_d     (in_dst),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .hit_d   (hit_d)
  );

  sbd_wb_ring #(.DEPTH(DEPTH), .RW(RW)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .alu_put (issue_o && is_alu),
    .mul_put (issue_o && is_mul),
    .div_put (div_claim),
    .put_dst (in_dst),
    .div_dst (div_dst),
    .sh0_v   (sh0_v),
    .sh1_v   (sh1_v),
    .wb_v    (wb_valid_o),
    .wb_dst  (wb_reg_o),
    .wb_unit (wb_unit_o)
  );

  sbd_div_track #(.LATW(LATW), .RW(RW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue_o && is_div),
    .lat      (in_div_lat),
    .dst      (in_dst),
    .sh0_v    (sh0_v),
    .done     (div_done_o),
    .busy     (div_busy),
    .want     (div_want),
    .claim    (div_claim),
    .held_dst (div_dst)
  );

  // R1
  alu_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_o && is_alu) |=> (wb_valid_o && wb_reg_o == $past(in_dst)
                             && wb_unit_o == UNIT_ALU));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!stall_o && !issue_o));

endmodule

// File: tb/sim_sbd_issue_ctrl.sv
`timescale 1ns/1ps
module sim_sbd_issue_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = 2'd0;
  logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [5:0] in_div_lat = '0;
  logic       stall_o, issue_o, wb_valid_o, div_done_o, div_busy_o;
  logic [4:0] wb_reg_o;
  logic [1:0] wb_unit_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sbd_issue_ctrl #(.NREG(32), .MUL_LAT(3), .LATW(6)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_div_lat(in_div_lat), .stall_o(stall_o), .issue_o(issue_o),
    .wb_valid_o(wb_valid_o), .wb_reg_o(wb_reg_o), .wb_unit_o(wb_unit_o),
    .div_done_o(div_done_o), .div_busy_o(div_busy_o)
  );

  localparam int NV = 26;
  // {valid, unit, src_a, src_b, dst, exp_stall, exp_wb_valid, exp_wb_reg}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd1, 5'd2, 5'd5,  1'b0, 1'b0, 5'd0},   // 0  R13 plain issue
    {1'b1, 2'd1, 5'd3, 5'd4, 5'd6,  1'b0, 1'b1, 5'd5},   // 1  R1
    {1'b1, 2'd0, 5'd5, 5'd0, 5'd7,  1'b0, 1'b0, 5'd0},   // 2  R3 after wb
    {1'b1, 2'd0, 5'd6, 5'd1, 5'd8,  1'b1, 1'b1, 5'd7},   // 3  R3 mul pending
    {1'b1, 2'd0, 5'd6, 5'd1, 5'd8,  1'b1, 1'b1, 5'd6},   // 4  R2 mul wb
    {1'b1, 2'd0, 5'd6, 5'd1, 5'd8,  1'b0, 1'b0, 5'd0},   // 5  R3 released
    {1'b1, 2'd1, 5'd0, 5'd0, 5'd9,  1'b0, 1'b1, 5'd8},   // 6  R1
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b0, 5'd0},   // 7  R13 idle
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd10, 1'b0, 1'b0, 5'd0},   // 8  R6 pushes mul
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd10},  // 9  R1
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd9},   // 10 R6 delayed mul
    {1'b1, 2'd1, 5'd0, 5'd0, 5'd11, 1'b0, 1'b0, 5'd0},   // 11 R2
    {1'b1, 2'd1, 5'd0, 5'd0, 5'd12, 1'b0, 1'b0, 5'd0},   // 12 R2
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd13, 1'b1, 1'b0, 5'd0},   // 13 R7 both slots
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd13, 1'b0, 1'b1, 5'd11},  // 14 R7 room again
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd13},  // 15 R6
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd12},  // 16 R6
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b0, 5'd0},   // 17 R5
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd0},   // 18 R5 no r0 dep
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd0},   // 19 R5
    {1'b1, 2'd1, 5'd0, 5'd0, 5'd14, 1'b0, 1'b0, 5'd0},   // 20 R2
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd14, 1'b1, 1'b0, 5'd0},   // 21 R4
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd14, 1'b1, 1'b0, 5'd0},   // 22 R4
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd14, 1'b1, 1'b1, 5'd14},  // 23 R4 wb cycle
    {1'b1, 2'd0, 5'd0, 5'd0, 5'd14, 1'b0, 1'b0, 5'd0},   // 24 R4 released
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0,  1'b0, 1'b1, 5'd14}   // 25 R4
  };
  localparam int REQ [NV] = '{13, 1, 3, 3, 2, 3, 1, 13, 6, 1, 6, 2, 2, 7, 7,
                               6, 6, 5, 5, 5, 2, 4, 4, 4, 4, 4};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] u, input logic [4:0] a,
                     input logic [4:0] b, input logic [4:0] d, input logic [5:0] lat);
    @(negedge clk);
    in_valid = v; in_unit = u; in_src_a = a; in_src_b = b; in_dst = d;
    in_div_lat = lat;
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 6'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog all-reqs act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset wb_valid", 32'(wb_valid_o), 32'd0);
    chk("R12 reset busy", 32'(div_busy_o), 32'd0);
    chk("R12 reset done", 32'(div_done_o), 32'd0);
    chk("R13 reset stall idle", 32'(stall_o), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][24], VEC[i][23:22], VEC[i][21:17], VEC[i][16:12], VEC[i][11:7], 6'd0);
      chk($sformatf("R%0d row %0d stall", REQ[i], i), 32'(stall_o), 32'(VEC[i][6]));
      chk($sformatf("R%0d row %0d issue", REQ[i], i), 32'(issue_o),
          32'(VEC[i][24] && !VEC[i][6]));
      chk($sformatf("R%0d row %0d wb_valid", REQ[i], i), 32'(wb_valid_o), 32'(VEC[i][5]));
      if (VEC[i][5])
        chk($sformatf("R%0d row %0d wb_reg", REQ[i], i), 32'(wb_reg_o), 32'(VEC[i][4:0]));
    end
    idle(4);

    // R3 second source operand
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd3, 6'd0);
    chk("R3 producer issues", 32'(stall_o), 32'd0);
    cyc(1'b1, 2'd0, 5'd0, 5'd3, 5'd4, 6'd0);
    chk("R3 src_b pending stall", 32'(stall_o), 32'd1);
    chk("R1 producer wb reg", 32'(wb_reg_o), 32'd3);
    cyc(1'b1, 2'd0, 5'd0, 5'd3, 5'd4, 6'd0);
    chk("R3 src_b released", 32'(stall_o), 32'd0);
    idle(4);

    // R8 R9 divide basics, latency 5
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd20, 6'd5);
    chk("R8 first divide issues", 32'(issue_o), 32'd1);
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd21, 6'd3);
    chk("R8 second divide stalls", 32'(stall_o), 32'd1);
    chk("R8 busy after issue", 32'(div_busy_o), 32'd1);
    idle(3);
    chk("R9 no early done", 32'(div_done_o), 32'd0);
    chk("R9 no early wb", 32'(wb_valid_o), 32'd0);
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd21, 6'd3);
    chk("R8 stall in done cycle", 32'(stall_o), 32'd1);
    chk("R9 done at N+L", 32'(div_done_o), 32'd1);
    chk("R9 divide wb reg", 32'(wb_reg_o), 32'd20);
    chk("R9 divide wb unit", 32'(wb_unit_o), 32'd2);
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd21, 6'd3);
    chk("R8 divide after done", 32'(issue_o), 32'd1);
    chk("R9 done one pulse", 32'(div_done_o), 32'd0);
    idle(1);
    // R10 divide claims port ahead of a candidate
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd22, 6'd0);
    chk("R10 candidate yields to divide", 32'(stall_o), 32'd1);
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd22, 6'd0);
    chk("R10 candidate issues after", 32'(stall_o), 32'd0);
    chk("R9 lat3 done", 32'(div_done_o), 32'd1);
    chk("R9 lat3 wb reg", 32'(wb_reg_o), 32'd21);
    idle(1);
    chk("R1 wb after divide", 32'(wb_reg_o), 32'd22);
    idle(3);

    // R9 latency below two
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd23, 6'd0);
    idle(1);
    chk("R9 lat0 not yet", 32'(wb_valid_o), 32'd0);
    idle(1);
    chk("R9 lat0 as 2 done", 32'(div_done_o), 32'd1);
    chk("R9 lat0 wb reg", 32'(wb_reg_o), 32'd23);
    idle(3);

    // R11 divide waits behind in-flight multiply
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd24, 6'd4);
    cyc(1'b1, 2'd1, 5'd0, 5'd0, 5'd25, 6'd0);
    chk("R2 multiply not blocked by divide", 32'(issue_o), 32'd1);
    idle(1);
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd26, 6'd0);
    chk("R10 stall while divide waits", 32'(stall_o), 32'd1);
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd26, 6'd0);
    chk("R10 stall at divide claim", 32'(stall_o), 32'd1);
    chk("R11 multiply keeps its cycle", 32'(wb_reg_o), 32'd25);
    chk("R11 multiply unit", 32'(wb_unit_o), 32'd1);
    chk("R11 divide not done yet", 32'(div_done_o), 32'd0);
    cyc(1'b1, 2'd0, 5'd0, 5'd0, 5'd26, 6'd0);
    chk("R11 candidate released", 32'(stall_o), 32'd0);
    chk("R11 divide done late", 32'(div_done_o), 32'd1);
    chk("R11 divide wb reg", 32'(wb_reg_o), 32'd24);
    idle(1);
    chk("R1 candidate wb", 32'(wb_reg_o), 32'd26);
    idle(3);

    // R13 idle with a hazard, then R12 reset mid-flight
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd28, 6'd30);
    cyc(1'b1, 2'd1, 5'd0, 5'd0, 5'd27, 6'd0);
    cyc(1'b0, 2'd0, 5'd27, 5'd0, 5'd0, 6'd0);
    chk("R13 no stall when idle", 32'(stall_o), 32'd0);
    chk("R13 no issue when idle", 32'(issue_o), 32'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R12 wb cleared", 32'(wb_valid_o), 32'd0);
    chk("R12 busy cleared", 32'(div_busy_o), 32'd0);
    rst = 1'b0;
    cyc(1'b1, 2'd0, 5'd27, 5'd0, 5'd29, 6'd0);
    chk("R12 pending cleared", 32'(stall_o), 32'd0);
    cyc(1'b1, 2'd2, 5'd0, 5'd0, 5'd30, 6'd2);
    chk("R12 divider free", 32'(stall_o), 32'd0);
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule